// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date. A clock enable at the timebase rate, 32.768 kHz by default, is divided down to a one-second tick. The tick advances a chain of packed-BCD counters: seconds, minutes, hours in 24-hour form, a weekday counter, the date, the month and a two-digit year. Every carry happens on the same clock edge as the tick that causes it. Month lengths and the February leap day are handled in hardware. The leap test treats a year value that is a multiple of four as a leap year, which holds for 2000 to 2099.

A host loads any single field through a one-cycle write strobe with a field selector. Writing the seconds field also restarts the prescaler, so the new second lasts its full length. A read request copies all seven fields into an output register on one edge, so a carry in progress cannot split the values. The block also raises one-cycle strobes for the second, minute, hour and day boundaries, for use by downstream alarm logic.

Top module: `bcd_rtc_core`

## Requirements
- R1: The block raises exactly one seconds tick per DIV clock cycles in which `tbase_en` is high. Cycles with `tbase_en` low do not count, and while the enable stays low no field changes.
- R2: Seconds and minutes roll from 59 to 00 and carry into the next field. Hours roll from 23 to 00 and carry into the day.
- R3: When the date steps past the last day of the month, it returns to 01 and the month increments. Months 04, 06, 09 and 11 have 30 days. Months 01, 03, 05, 07, 08, 10 and 12 have 31.
- R4: February has 29 days when the BCD year value is a multiple of four, and 28 days otherwise.
- R5: After month 12 the month returns to 01 and the year increments. Year 99 wraps to 00.
- R6: The weekday counts from 1 to 7 and advances at every midnight. After 7 it wraps to 1.
- R7: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_sel` on that edge. The codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. All fields hold packed BCD.
- R8: A write to the seconds field clears the prescaler and cancels any tick due on that edge. The next tick comes after DIV further enabled cycles.
- R9: On the edge where `rd_req` is high, all fields are copied into `rd_data`. `rd_valid` is high for the following cycle only. The copy holds the values from before that edge, even when a carry happens on the same edge. The layout is: seconds in [7:0], minutes in [15:8], hours in [23:16], weekday in [31:24], date in [39:32], month in [47:40] and year in [55:48].
- R10: `sec_tick` is high in the cycle whose closing edge advances the seconds. `min_tick` is high when that edge also wraps the seconds. `hour_tick` is high when it also wraps the minutes. `day_tick` is high when it also wraps the hours.
- R11: After reset the time is 00:00:00, the weekday is 1, the date is 01-01-00 and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase_en | input | 1 | Timebase clock enable, one pulse per timebase period |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | BCD value to load |
| rd_req | input | 1 | Snapshot request |
| rd_valid | output | 1 | Snapshot data valid, one cycle |
| rd_data | output | 56 | Snapshot of all seven fields |
| sec_tick | output | 1 | Seconds advance strobe |
| min_tick | output | 1 | Minute boundary strobe |
| hour_tick | output | 1 | Hour boundary strobe |
| day_tick | output | 1 | Midnight strobe |

## Verification
The counter chain is started from many preset times. These include a plain minute wrap, an hour wrap, midnight at the end of each month length, February 28 and 29 in leap and non-leap years, the last day of year 99, and weekday 7 at midnight. Each preset separates one carry path from the others. The strobe counts show whether each boundary fired exactly once. A hold with the enable low separates counting of enabled cycles from counting of clock cycles. A seconds write in mid-second shows whether the prescaler phase is cleared. A snapshot taken on the carry edge itself shows whether the read returns pre-edge values or a torn mix.

// File: rtl/rtc_pkg.sv
// Package: shared field codes and BCD helpers for the clock/calendar block.
// Assumes every field value is valid packed BCD.
package rtc_pkg;

    localparam int FIELD_W = 8;
    localparam int NFIELDS = 7;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } fld_e;

    // Increment a two-digit packed BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    // Leap test on a BCD year: the value is a multiple of 4 (10 = 2 mod 4).
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [3:0] adj;
        adj = yr[4] ? (yr[3:0] + 4'd2) : yr[3:0];
        return (adj[1:0] == 2'b00);
    endfunction

    // Last date of a BCD month in a BCD year.
    function automatic logic [7:0] bcd_last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Prescaler: counts enabled timebase cycles and emits a one-second tick.
// Assumes DIV >= 2. A clear restarts the count and cancels a pending tick.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tbase_en,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Tick when the final enabled cycle of a second is reached.
    assign tick = tbase_en && (cnt_q == LAST) && !clear;

    // Count enabled cycles, wrap at DIV, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (tbase_en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
endmodule

// File: rtl/rtc_time_counter.sv
// Time counter: seconds, minutes, hours (24 h) in packed BCD.
// Assumes written values are valid BCD in range; a write overrides the
// advance of that field only.
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] sec_q,
    output logic [FIELD_W-1:0] min_q,
    output logic [FIELD_W-1:0] hour_q,
    output logic               sec_wrap,
    output logic               min_wrap,
    output logic               day_wrap
);
    // Carry chain derived from the current values.
    assign sec_wrap = tick && (sec_q == 8'h59);
    assign min_wrap = sec_wrap && (min_q == 8'h59);
    assign day_wrap = min_wrap && (hour_q == 8'h23);

    // Seconds: load, or advance on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sec_q <= 8'h00;
        else if (wr_en && wr_sel == FLD_SEC) sec_q <= wr_data;
        else if (sec_wrap)                   sec_q <= 8'h00;
        else if (tick)                       sec_q <= bcd_inc(sec_q);
    end

    // Minutes: load, or advance when seconds wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                          min_q <= 8'h00;
        else if (wr_en && wr_sel == FLD_MIN) min_q <= wr_data;
        else if (min_wrap)                   min_q <= 8'h00;
        else if (sec_wrap)                   min_q <= bcd_inc(min_q);
    end

    // Hours: load, or advance when minutes wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hour_q <= 8'h00;
        else if (wr_en && wr_sel == FLD_HOUR) hour_q <= wr_data;
        else if (day_wrap)                    hour_q <= 8'h00;
        else if (min_wrap)                    hour_q <= bcd_inc(hour_q);
    end
endmodule

// File: rtl/rtc_date_counter.sv
// Date counter: weekday, date, month, two-digit year in packed BCD.
// Assumes valid BCD writes; the leap rule is exact for years 2000..2099.
module rtc_date_counter
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               day_inc,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] wday_q,
    output logic [FIELD_W-1:0] date_q,
    output logic [FIELD_W-1:0] month_q,
    output logic [FIELD_W-1:0] year_q
);
    logic [FIELD_W-1:0] last_day;
    logic               mon_wrap;
    logic               yr_wrap;

    // Month-end and year-end carries for the current date.
    assign last_day = bcd_last_day(month_q, year_q);
    assign mon_wrap = day_inc && (date_q == last_day);
    assign yr_wrap  = mon_wrap && (month_q == 8'h12);

    // Weekday: 1..7, advances at every midnight.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wday_q <= 8'h01;
        else if (wr_en && wr_sel == FLD_WDAY) wday_q <= wr_data;
        else if (day_inc)                     wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;
    end

    // Date: returns to 01 after the month's last day.
    always_ff @(posedge clk) begin
        if (!rst_n)                           date_q <= 8'h01;
        else if (wr_en && wr_sel == FLD_DATE) date_q <= wr_data;
        else if (mon_wrap)                    date_q <= 8'h01;
        else if (day_inc)                     date_q <= bcd_inc(date_q);
    end

    // Month: returns to 01 after 12.
    always_ff @(posedge clk) begin
        if (!rst_n)                            month_q <= 8'h01;
        else if (wr_en && wr_sel == FLD_MONTH) month_q <= wr_data;
        else if (yr_wrap)                      month_q <= 8'h01;
        else if (mon_wrap)                     month_q <= bcd_inc(month_q);
    end

    // Year: 00..99 with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                           year_q <= 8'h00;
        else if (wr_en && wr_sel == FLD_YEAR) year_q <= wr_data;
        else if (yr_wrap)                     year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
endmodule

// File: rtl/bcd_rtc_core.sv
// Top: prescaler, time and date counters, snapshot register and strobes.
// Assumes one field write per cycle; a seconds write restarts the second.
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbase_en,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [FIELD_W-1:0]         wr_data,
    input  logic                       rd_req,
    output logic                       rd_valid,
    output logic [NFIELDS*FIELD_W-1:0] rd_data,
    output logic                       sec_tick,
    output logic                       min_tick,
    output logic                       hour_tick,
    output logic                       day_tick
);
    logic               sec_wr;
    logic               tick;
    logic               sec_wrap, min_wrap, day_wrap;
    logic [FIELD_W-1:0] sec_q, min_q, hour_q, wday_q, date_q, month_q, year_q;
    logic [FIELD_W-1:0] live [NFIELDS];
    logic [FIELD_W-1:0] snap_q [NFIELDS];

    assign sec_wr = wr_en && (wr_sel == FLD_SEC);

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbase_en (tbase_en),
        .clear    (sec_wr),
        .tick     (tick)
    );

    rtc_time_counter u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .sec_q    (sec_q),
        .min_q    (min_q),
        .hour_q   (hour_q),
        .sec_wrap (sec_wrap),
        .min_wrap (min_wrap),
        .day_wrap (day_wrap)
    );

    rtc_date_counter u_date (
        .clk     (clk),
        .rst_n   (rst_n),
        .day_inc (day_wrap),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wday_q  (wday_q),
        .date_q  (date_q),
        .month_q (month_q),
        .year_q  (year_q)
    );

    // Boundary strobes for downstream alarm logic.
    assign sec_tick  = tick;
    assign min_tick  = sec_wrap;
    assign hour_tick = min_wrap;
    assign day_tick  = day_wrap;

    // Field order in the snapshot, lowest byte first.
    assign live[0] = sec_q;
    assign live[1] = min_q;
    assign live[2] = hour_q;
    assign live[3] = wday_q;
    assign live[4] = date_q;
    assign live[5] = month_q;
    assign live[6] = year_q;

    genvar gi;
    generate
        for (gi = 0; gi < NFIELDS; gi++) begin : g_snap
            // Capture one field on a read request.
            always_ff @(posedge clk) begin
                if (!rst_n)      snap_q[gi] <= '0;
                else if (rd_req) snap_q[gi] <= live[gi];
            end
            assign rd_data[gi*FIELD_W +: FIELD_W] = snap_q[gi];
        end
    endgenerate

    // Flag the snapshot for one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_req;
    end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
// Checker for bcd_rtc_core: strobe nesting, snapshot timing and field ranges.
module bcd_rtc_core_chk
    import rtc_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [SEL_W-1:0]           wr_sel,
    input logic                       rd_req,
    input logic                       rd_valid,
    input logic [NFIELDS*FIELD_W-1:0] rd_data,
    input logic                       sec_tick,
    input logic                       min_tick,
    input logic                       hour_tick,
    input logic                       day_tick,
    input logic [FIELD_W-1:0]         sec_q
);
    // R10
    min_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> sec_tick);

    // R10
    day_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        day_tick |-> (hour_tick && min_tick));

    // R9
    snap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R9
    snap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R8
    sec_wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FLD_SEC) |=> !sec_tick);

    // R2
    sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec_q == 8'h59) |=> (sec_q == 8'h00));

    // R6
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[31:24] >= 8'h01 && rd_data[31:24] <= 8'h07));

    // R3
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[39:32] >= 8'h01 && rd_data[39:32] <= 8'h31));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .sec_tick  (sec_tick),
    .min_tick  (min_tick),
    .hour_tick (hour_tick),
    .day_tick  (day_tick),
    .sec_q     (sec_q)
);

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks preset the time and request snapshots, pushing the
// value a calendar model predicts; a monitor pops and compares on rd_valid.
module bcd_rtc_core_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbase_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [55:0] rd_data;
    logic        sec_tick, min_tick, hour_tick, day_tick;

    int n_run = 0;
    int n_fail = 0;
    int c_sec = 0, c_min = 0, c_hour = 0, c_day = 0;
    int m_y, m_mo, m_d, m_w, m_h, m_mi, m_s;

    logic [55:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    bcd_rtc_core #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tbase_en(tbase_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .sec_tick(sec_tick), .min_tick(min_tick),
        .hour_tick(hour_tick), .day_tick(day_tick)
    );

    task automatic check(input bit ok, input string tag, input logic [55:0] act, input logic [55:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int month_len(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Reference calendar: advance the model by one second.
    task automatic model_step();
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin
            m_h = 0;
            m_w = (m_w == 7) ? 1 : m_w + 1;
            m_d++;
            if (m_d > month_len(m_mo, m_y)) begin m_d = 1; m_mo++; end
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y == 99) ? 0 : m_y + 1; end
        end
    endtask

    function automatic logic [55:0] model_pack();
        return {to_bcd(m_y), to_bcd(m_mo), to_bcd(m_d), to_bcd(m_w),
                to_bcd(m_h), to_bcd(m_mi), to_bcd(m_s)};
    endfunction

    task automatic wr_one(input int sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = to_bcd(val);
    endtask

    // Preset every field (R7); seconds last, enabling the timebase with it.
    task automatic set_time(input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s);
        tbase_en = 1'b0;
        wr_one(6, y); wr_one(5, mo); wr_one(4, d); wr_one(3, w);
        wr_one(2, h); wr_one(1, mi); wr_one(0, s);
        tbase_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_y = y; m_mo = mo; m_d = d; m_w = w; m_h = h; m_mi = mi; m_s = s;
        c_sec = 0; c_min = 0; c_hour = 0; c_day = 0;
    endtask

    // Write only the seconds field (R8), timebase left as it is.
    task automatic wr_sec(input int s);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = to_bcd(s);
        @(negedge clk);
        wr_en = 1'b0;
        m_s = s;
    endtask

    // Snapshot on the n-th edge after the last write edge; ticks land on
    // edges DIV, 2*DIV, ... so (n-1)/DIV seconds precede the capture.
    task automatic read_at(input int n, input string tag);
        repeat (n - 1) @(negedge clk);
        if (tbase_en)
            for (int i = 0; i < (n - 1) / DIV; i++) model_step();
        exp_q.push_back(model_pack());
        tag_q.push_back(tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_strobes(input int es, input int em, input int eh, input int ed, input string tag);
        check(c_sec == es && c_min == em && c_hour == eh && c_day == ed, tag,
              56'({c_sec[7:0], c_min[7:0], c_hour[7:0], c_day[7:0]}),
              56'({es[7:0], em[7:0], eh[7:0], ed[7:0]}));
    endtask

    // Strobe counters, sampled with inputs settled since the previous negedge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (sec_tick)  c_sec++;
            if (min_tick)  c_min++;
            if (hour_tick) c_hour++;
            if (day_tick)  c_day++;
        end
    end

    // Monitor: compare each snapshot against the queued prediction.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rd_valid", rd_data, '0);
            end else begin
                logic [55:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0 && sec_tick == 1'b0, "R11 outputs in reset",
              56'({rd_valid, sec_tick}), '0);
        rst_n = 1'b1;
        m_y = 0; m_mo = 1; m_d = 1; m_w = 1; m_h = 0; m_mi = 0; m_s = 0;
        read_at(1, "R11 reset values");

        set_time(31, 7, 15, 3, 14, 27, 33);
        read_at(1, "R7 all fields loaded");

        set_time(25, 6, 10, 2, 10, 15, 59);
        read_at(DIV + 1, "R2 minute wrap");
        check_strobes(1, 1, 0, 0, "R10 strobes minute wrap");

        set_time(25, 6, 10, 2, 22, 59, 59);
        read_at(DIV + 1, "R2 hour wrap");
        check_strobes(1, 1, 1, 0, "R10 strobes hour wrap");

        set_time(24, 2, 28, 3, 23, 59, 58);
        read_at(3 * DIV + 1, "R4 leap Feb 28 to 29");
        check_strobes(3, 1, 1, 1, "R10 strobes midnight");

        set_time(23, 2, 28, 2, 23, 59, 59);
        read_at(DIV + 1, "R4 non-leap Feb 28 to Mar 01");

        set_time(24, 2, 29, 4, 23, 59, 59);
        read_at(DIV + 1, "R4 leap Feb 29 to Mar 01");

        set_time(25, 4, 30, 3, 23, 59, 59);
        read_at(DIV + 1, "R3 30-day month end");

        set_time(25, 1, 31, 5, 23, 59, 59);
        read_at(DIV + 1, "R3 31-day month end");

        set_time(25, 1, 30, 4, 23, 59, 59);
        read_at(DIV + 1, "R3 Jan 30 to 31 no month carry");

        set_time(23, 12, 31, 7, 23, 59, 59);
        read_at(DIV + 1, "R5 R6 new year and weekday wrap");

        set_time(99, 12, 31, 4, 23, 59, 59);
        read_at(2 * DIV + 1, "R5 year 99 wraps to 00");

        set_time(23, 12, 31, 7, 23, 59, 59);
        read_at(DIV, "R9 snapshot on carry edge");

        set_time(25, 8, 20, 6, 8, 30, 0);
        read_at(5 * DIV + 1, "R1 five seconds counted");

        set_time(25, 8, 20, 6, 8, 30, 0);
        tbase_en = 1'b0;
        read_at(3 * DIV + 1, "R1 enable low holds time");

        set_time(25, 8, 20, 6, 8, 30, 10);
        wr_sec(20);
        read_at(DIV, "R8 seconds write restarts prescaler");

        tbase_en = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all snapshots returned",
              56'(exp_q.size()), '0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule